// File: doc/BRIEF.md
# Video Timing Code Field Marker

This block watches a stream of 8-bit BT.656 video bytes, taking one byte on each clock, and finds the four-byte timing reference codes in it. Each code is the preamble FF, 00, 00 followed by a status byte. The block drives two signals to a linear capture engine that writes each video field into its own buffer. `start_o` is a one-clock pulse on four chosen end-of-field codes. `stop_o` is a level that is high over part of each field.

After reset the block stays idle and ignores all codes except an arming code, FF 00 00 EC. Once it has seen that code it is active. It stays active until the enable input drops or reset is asserted. Both outputs come from registers. Each output changes on the clock edge that samples the last byte of the matching code.

Top module: `vtc_field_marker`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `start_o` and `stop_o` are 0 and the block is idle. A code that needs the active state gives no output until the arming code has been seen again.
- R2: Codes are found with a history that shifts on every clock. A preamble that follows other preamble-like bytes is still found, for example FF FF 00 00 F1 or FF FF FF 00 00 B6.
- R3: In the idle state both outputs stay 0 on every code. The status byte EC after the preamble moves the block to the active state. That arming code produces no start pulse.
- R4: In the active state, `start_o` goes high for exactly one clock after the edge that samples status byte 9D, DA, F1 or B6 following the preamble. It is low on the next clock unless another such code completes.
- R5: In the active state, other status bytes such as 80, AB, C7 and EC leave `stop_o` unchanged and give no start pulse.
- R6: In the active state, status byte F1 sets `stop_o` on the same edge as its start pulse. Status byte B6 clears it. Between those codes `stop_o` holds its value.
- R7: An edge at which `en_i` is 0 returns the block to the idle state and clears both outputs, even if a code completes on that edge. After `en_i` goes back to 1, the arming code is needed again.
- R8: A status byte that does not follow the exact preamble FF, 00, 00 has no effect. Examples are FF 00 01 F1 and 10 00 00 F1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable. 0 holds the block idle |
| data_i | input | 8 | Video byte sampled on each rising edge |
| start_o | output | 1 | One-clock pulse on selected field codes |
| stop_o | output | 1 | Level set by F1 and cleared by B6 |

## Verification
The start pulse and a change of the stop level fall in the same cycle on codes F1 and B6. The bench sends each of these codes while `stop_o` is in each of its two states. It checks that both outputs show the right values on the same sample after the status byte. A second collision is a code completing on the edge where enable drops. There, the bench expects both outputs to be 0 and no pulse.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned PRE_LEN   = 3;

  localparam logic [DATA_W-1:0] PREAMBLE [PRE_LEN] = '{8'hFF, 8'h00, 8'h00};

  localparam logic [DATA_W-1:0] CODE_ARM   = 8'hEC;
  localparam logic [DATA_W-1:0] CODE_EOF_A = 8'h9D;
  localparam logic [DATA_W-1:0] CODE_EOF_B = 8'hDA;
  localparam logic [DATA_W-1:0] CODE_SET   = 8'hF1;
  localparam logic [DATA_W-1:0] CODE_CLR   = 8'hB6;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_ARM,
    KIND_MARK,
    KIND_MARK_SET,
    KIND_MARK_CLR
  } code_kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_ACTIVE
  } mode_e;
endpackage

// File: rtl/vtc_byte_history.sv
module vtc_byte_history #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] hist_o [DEPTH]
);
  logic [DATA_W-1:0] hist_q [DEPTH];

  // hist_q[0] newest, hist_q[DEPTH-1] oldest
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    hist_q[g] <= '0;
      else if (g == 0) hist_q[g] <= data_i;
      else            hist_q[g] <= hist_q[(g == 0) ? 0 : g-1];
    end
    assign hist_o[g] = hist_q[g];
  end
endmodule

// File: rtl/vtc_code_decode.sv
module vtc_code_decode
  import vtc_pkg::*;
#(
  parameter int unsigned DEPTH = PRE_LEN
) (
  input  logic [DATA_W-1:0] hist_i [DEPTH],
  input  logic [DATA_W-1:0] data_i,
  output code_kind_e        kind_o
);
  logic [DEPTH-1:0] pre_hit;

  // PREAMBLE[0] is the oldest byte
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign pre_hit[g] = (hist_i[DEPTH-1-g] == PREAMBLE[g]);
  end

  always_comb begin
    kind_o = KIND_NONE;
    if (&pre_hit) begin
      unique case (data_i)
        CODE_ARM:               kind_o = KIND_ARM;
        CODE_EOF_A, CODE_EOF_B: kind_o = KIND_MARK;
        CODE_SET:               kind_o = KIND_MARK_SET;
        CODE_CLR:               kind_o = KIND_MARK_CLR;
        default:                kind_o = KIND_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vtc_mark_ctrl.sv
module vtc_mark_ctrl
  import vtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  code_kind_e kind_i,
  output logic       active_o,
  output logic       start_o,
  output logic       stop_o
);
  mode_e mode_q;
  logic  start_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= ST_IDLE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (!en_i) begin
      mode_q  <= ST_IDLE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      unique case (mode_q)
        ST_IDLE: begin
          start_q <= 1'b0;
          stop_q  <= 1'b0;
          if (kind_i == KIND_ARM) mode_q <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          start_q <= (kind_i == KIND_MARK) || (kind_i == KIND_MARK_SET) ||
                     (kind_i == KIND_MARK_CLR);
          if (kind_i == KIND_MARK_SET)      stop_q <= 1'b1;
          else if (kind_i == KIND_MARK_CLR) stop_q <= 1'b0;
        end
        default: mode_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o = (mode_q == ST_ACTIVE);
  assign start_o  = start_q;
  assign stop_o   = stop_q;
endmodule

// File: rtl/vtc_field_marker.sv
module vtc_field_marker
  import vtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output logic              stop_o
);
  logic [DATA_W-1:0] hist [PRE_LEN];
  code_kind_e        kind;
  logic              active;

  vtc_byte_history #(.DATA_W(DATA_W), .DEPTH(PRE_LEN)) i_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .hist_o (hist)
  );

  vtc_code_decode #(.DEPTH(PRE_LEN)) i_dec (
    .hist_i (hist),
    .data_i (data_i),
    .kind_o (kind)
  );

  vtc_mark_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .kind_i   (kind),
    .active_o (active),
    .start_o  (start_o),
    .stop_o   (stop_o)
  );
endmodule

// File: rtl/vtc_field_marker_chk.sv
module vtc_field_marker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [7:0] data_i,
  input logic       start_o,
  input logic       stop_o
);
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R4

  AST_START_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(en_i) && $past(data_i, 4) == 8'hFF &&
                 $past(data_i, 3) == 8'h00 && $past(data_i, 2) == 8'h00 &&
                 ($past(data_i) == 8'h9D || $past(data_i) == 8'hDA ||
                  $past(data_i) == 8'hF1 || $past(data_i) == 8'hB6))); // R4

  AST_STOP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> ($past(data_i) == 8'hF1 && start_o)); // R6

  AST_STOP_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) |-> ($past(data_i) == 8'hB6 || !$past(en_i))); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!start_o && !stop_o)); // R7
endmodule

bind vtc_field_marker vtc_field_marker_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .data_i  (data_i),
  .start_o (start_o),
  .stop_o  (stop_o)
);

// File: tb/test_vtc_field_marker.sv
module test_vtc_field_marker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] data_i = 8'h10;
  logic       start_o, stop_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vtc_field_marker i_vtc_field_marker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .data_i (data_i),
    .start_o(start_o),
    .stop_o (stop_o)
  );

  task automatic chk(input string req, input logic act_s, input logic exp_s,
                     input logic act_p, input logic exp_p);
    n_run++;
    if (act_s !== exp_s || act_p !== exp_p) begin
      n_fail++;
      $display("FAIL %s: start=%b stop=%b expected start=%b stop=%b",
               req, act_s, act_p, exp_s, exp_p);
    end
  endtask

  // drive at falling edge, observe 1 ns after the sampling edge
  task automatic put(input logic [7:0] b);
    @(negedge clk_i);
    data_i = b;
    @(posedge clk_i);
    #1;
  endtask

  task automatic put_code(input logic [7:0] c);
    put(8'hFF); put(8'h00); put(8'h00); put(c);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i   = 1'b1;
    data_i = 8'h10;
    #1;
    chk("R1 in reset", start_o, 1'b0, stop_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    put(8'h10);
    chk("R1 after reset", start_o, 1'b0, stop_o, 1'b0);
  endtask

  task automatic t_idle();
    put_code(8'hF1);
    chk("R3 idle F1", start_o, 1'b0, stop_o, 1'b0);
    put_code(8'h9D);
    chk("R3 idle 9D", start_o, 1'b0, stop_o, 1'b0);
    put_code(8'hEC);
    chk("R3 arm no pulse", start_o, 1'b0, stop_o, 1'b0);
  endtask

  task automatic t_pulse();
    put(8'h10);
    put_code(8'h9D);
    chk("R4 pulse 9D", start_o, 1'b1, stop_o, 1'b0);
    put(8'h10);
    chk("R4 pulse ends", start_o, 1'b0, stop_o, 1'b0);
    put_code(8'hDA);
    chk("R4 pulse DA", start_o, 1'b1, stop_o, 1'b0);
  endtask

  task automatic t_stop();
    put_code(8'hF1);
    chk("R6 F1 set with pulse", start_o, 1'b1, stop_o, 1'b1);
    put(8'h55); put(8'h20);
    chk("R6 stop holds", start_o, 1'b0, stop_o, 1'b1);
    put_code(8'hDA);
    chk("R6 stop kept over DA", start_o, 1'b1, stop_o, 1'b1);
    put_code(8'hF1);
    chk("R6 F1 again", start_o, 1'b1, stop_o, 1'b1);
    put_code(8'hB6);
    chk("R6 B6 clear with pulse", start_o, 1'b1, stop_o, 1'b0);
    put_code(8'hB6);
    chk("R6 B6 while low", start_o, 1'b1, stop_o, 1'b0);
  endtask

  task automatic t_other();
    put_code(8'hF1);
    put_code(8'h80);
    chk("R5 code 80", start_o, 1'b0, stop_o, 1'b1);
    put_code(8'hAB);
    chk("R5 code AB", start_o, 1'b0, stop_o, 1'b1);
    put_code(8'hC7);
    chk("R5 code C7", start_o, 1'b0, stop_o, 1'b1);
    put_code(8'hEC);
    chk("R5 code EC", start_o, 1'b0, stop_o, 1'b1);
  endtask

  task automatic t_overlap();
    put(8'hFF); put(8'hFF); put(8'hFF); put(8'h00); put(8'h00); put(8'hB6);
    chk("R2 FFFFFF0000B6", start_o, 1'b1, stop_o, 1'b0);
    put(8'hFF); put(8'hFF); put(8'h00); put(8'h00); put(8'hF1);
    chk("R2 FFFF0000F1", start_o, 1'b1, stop_o, 1'b1);
  endtask

  task automatic t_no_pre();
    put(8'hFF); put(8'h00); put(8'h01); put(8'hB6);
    chk("R8 FF0001B6", start_o, 1'b0, stop_o, 1'b1);
    put(8'h10); put(8'h00); put(8'h00); put(8'hB6);
    chk("R8 100000B6", start_o, 1'b0, stop_o, 1'b1);
  endtask

  task automatic t_disable();
    put(8'hFF); put(8'h00); put(8'h00);
    @(negedge clk_i);
    en_i = 1'b0;
    data_i = 8'hB6;
    @(posedge clk_i); #1;
    chk("R7 code on disable edge", start_o, 1'b0, stop_o, 1'b0);
    @(negedge clk_i);
    en_i = 1'b1;
    put_code(8'hF1);
    chk("R7 re-enabled is idle", start_o, 1'b0, stop_o, 1'b0);
    put_code(8'hEC);
    put_code(8'hF1);
    chk("R7 re-armed", start_o, 1'b1, stop_o, 1'b1);
  endtask

  task automatic t_mid_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", start_o, 1'b0, stop_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    put_code(8'hF1);
    chk("R1 idle after reset", start_o, 1'b0, stop_o, 1'b0);
  endtask

  initial begin
    do_reset();
    t_idle();
    t_pulse();
    t_stop();
    t_other();
    t_overlap();
    t_no_pre();
    t_disable();
    t_mid_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: start=%b stop=%b expected run to end", start_o, stop_o);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule